// File: doc/BRIEF.md
# Serial EEPROM Slave Command Controller

This block is the command engine of a two-wire serial memory slave. A bus-condition detector in front of it turns the raw clock and data lines into single-cycle strobes: start (also used for a repeated start), stop, SCL rising and SCL falling. Alongside these strobes it supplies the current level of the data line. The controller decodes the control byte and keeps one address pointer that reads and writes share. It gathers written bytes in a small page buffer, which is copied into a 256 x 8 synchronous memory model only when the bus master ends the write phase cleanly. For reads it sends bytes out MSB first through an open-drain pull-down enable.

A busy level comes in from the write-cycle controller. While that level is high, the block acknowledges nothing, so the master can poll for write completion by sending a write-type control byte. When a write is committed, the block emits a one-cycle pulse that starts the write-cycle controller. The pointer starts at the word address given in a write command. For writes, only its low page bits advance. For reads, the whole pointer advances, so a read with no address starts one past the last byte accessed.

Top module: `smem_slave_ctrl`

## Requirements
- R1: A control byte is acknowledged when its top four bits are 1010, whatever bits 3..1 hold, and busy_i is low. Bit 0 selects read (1) or write (0). Any other top nibble gets no acknowledge, and the rest of that transaction gets none either.
- R2: While busy_i is high, no byte is acknowledged, including a matching control byte. Once busy_i is low again, the same control byte is acknowledged.
- R3: After a write control byte is acknowledged, the next byte becomes the pointer. A data byte followed by a stop at a byte boundary is written at that address, and commit_o pulses for exactly the one cycle after the stop strobe.
- R4: In a write, each data byte advances only the low three pointer bits. Writing more than 8 bytes wraps inside the aligned 8-byte page and overwrites the earliest bytes of that write.
- R5: A read with no word address returns the byte at the last accessed address plus one. After a write this is the next offset within the page.
- R6: A write control byte, a word address, a repeated start and a read control byte read from that address. No commit is produced.
- R7: In a read, each master ACK (data line low in the ninth clock) sends the byte at the next pointer value. The pointer wraps from 255 to 0.
- R8: After a master NACK, the data line is not driven until the next start.
- R9: A start or stop in the middle of a byte aborts the transaction. No commit happens, and memory keeps its old contents.
- R10: sda_oe_o changes only in the cycle after an SCL-fall, start or stop strobe, so it is steady while SCL is high.
- R11: After reset, sda_oe_o and commit_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or repeated-start strobe from the bus-condition detector |
| stop_i | input | 1 | Stop strobe |
| scl_rise_i | input | 1 | SCL rising strobe; sda_i is sampled on it |
| scl_fall_i | input | 1 | SCL falling strobe; the output may change after it |
| sda_i | input | 1 | Resolved level of the data line |
| busy_i | input | 1 | Internal write cycle in progress; withholds all acknowledges |
| sda_oe_o | output | 1 | 1 pulls the data line low (ACK or a 0 data bit) |
| commit_o | output | 1 | One-cycle pulse when buffered write data is committed |

## Verification
The hardest case to reach is page-write wraparound, because it only shows when more than eight data bytes land inside one page starting at a middle offset. The stimulus writes ten bytes from offset 4 of one page. It then reads that page back byte by byte with master ACKs. Every slot is checked against the bytes that should have survived the overwrite. The nearby aborts come from strobing a stop or a repeated start partway through a data byte, and also right after a full data byte. After each abort the address is read back to confirm the old contents remain.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_WAIT
  } phase_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/smem_ram.sv
module smem_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/smem_shift.sv
module smem_shift #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          rise,
  input  logic          sda,
  input  logic          tx_load,
  input  logic [W-1:0]  tx_data,
  input  logic          tx_shift,
  output logic          byte_done,
  output logic          ack_slot,
  output logic [W-1:0]  rx_byte,
  output logic [CW-1:0] bitcnt,
  output logic          tx_msb
);
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);
  localparam logic [CW-1:0] ACK_BIT  = CW'(W);

  logic [W-2:0] rx_sh;
  logic [W-1:0] tx_sh;

  // Bit slot counter: 0..W-1 data bits, W is the acknowledge slot.
  always_ff @(posedge clk) begin
    if (rst || clr)   bitcnt <= '0;
    else if (rise)    bitcnt <= (bitcnt == ACK_BIT) ? '0 : bitcnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)       rx_sh <= '0;
    else if (rise) rx_sh <= {rx_sh[W-3:0], sda};
  end

  always_ff @(posedge clk) begin
    if (rst)           tx_sh <= '0;
    else if (tx_load)  tx_sh <= tx_data;
    else if (tx_shift) tx_sh <= {tx_sh[W-2:0], 1'b0};
  end

  assign byte_done = rise && (bitcnt == LAST_BIT);
  assign ack_slot  = rise && (bitcnt == ACK_BIT);
  assign rx_byte   = {rx_sh, sda};
  assign tx_msb    = tx_sh[W-1];
endmodule

// File: rtl/smem_page_buf.sv
module smem_page_buf #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic [AW-PW-1:0] base,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  localparam int DEPTH = 2 ** PW;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic             draining;
  logic [PW-1:0]    idx;
  logic [AW-PW-1:0] base_q;
  logic             wr_ok;

  assign wr_ok = wr_en && !draining && !commit && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      draining <= 1'b0;
      idx      <= '0;
      base_q   <= '0;
    end else if (draining) begin
      idx <= idx + PW'(1);
      if (idx == LAST) begin
        draining <= 1'b0;
        valid_q  <= '0;
      end
    end else if (commit) begin
      draining <= 1'b1;
      idx      <= '0;
      base_q   <= base;
    end else if (clr) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) data_q[wr_off] <= wr_data;
  end

  assign mem_we    = draining && valid_q[idx];
  assign mem_waddr = {base_q, idx};
  assign mem_wdata = data_q[idx];
endmodule

// File: rtl/smem_slave_ctrl.sv
module smem_slave_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PW = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic sda_i,
  input  logic busy_i,
  output logic sda_oe_o,
  output logic commit_o
);
  import smem_pkg::*;

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] DATA_BITS = CW'(DW);

  phase_e        phase;
  logic [AW-1:0] ptr;
  logic [DW-1:0] byte_q;
  logic          ack_pend, is_read, data_seen;

  logic          byte_done, ack_slot, tx_msb;
  logic [DW-1:0] rx_byte, mem_q;
  logic [CW-1:0] bitcnt;

  logic ctrl_ok, mem_re, buf_wr, buf_clr, commit, tx_load, tx_shift;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  always_comb begin
    ctrl_ok  = (rx_byte[DW-1 -: 4] == DEV_CODE) && !busy_i;
    mem_re   = byte_done && ((phase == PH_CTRL && ctrl_ok && rx_byte[0]) ||
                             phase == PH_RDATA);
    buf_wr   = ack_slot && phase == PH_WDATA;
    buf_clr  = start_i || (ack_slot && phase == PH_ADDR);
    commit   = stop_i && phase == PH_WDATA && bitcnt == '0 && data_seen;
    tx_load  = ack_slot && ((phase == PH_CTRL && is_read) ||
                            (phase == PH_RDATA && !sda_i));
    tx_shift = scl_rise_i && phase == PH_RDATA && bitcnt < DATA_BITS;
  end

  smem_shift #(.W(DW), .CW(CW)) u_shift (
    .clk(clk), .rst(rst), .clr(start_i), .rise(scl_rise_i), .sda(sda_i),
    .tx_load(tx_load), .tx_data(mem_q), .tx_shift(tx_shift),
    .byte_done(byte_done), .ack_slot(ack_slot), .rx_byte(rx_byte),
    .bitcnt(bitcnt), .tx_msb(tx_msb)
  );

  smem_page_buf #(.AW(AW), .DW(DW), .PW(PW)) u_pbuf (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr_en(buf_wr),
    .wr_off(ptr[PW-1:0]), .wr_data(byte_q), .commit(commit),
    .base(ptr[AW-1:PW]), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  smem_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(ptr), .rdata(mem_q)
  );

  // Transaction sequencing.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      ptr       <= '0;
      byte_q    <= '0;
      ack_pend  <= 1'b0;
      is_read   <= 1'b0;
      data_seen <= 1'b0;
    end else if (start_i) begin
      phase     <= PH_CTRL;
      ack_pend  <= 1'b0;
      data_seen <= 1'b0;
    end else if (stop_i) begin
      phase    <= PH_IDLE;
      ack_pend <= 1'b0;
    end else begin
      if (byte_done) begin
        byte_q <= rx_byte;
        unique case (phase)
          PH_CTRL: begin
            if (ctrl_ok) begin
              ack_pend <= 1'b1;
              is_read  <= rx_byte[0];
            end else begin
              phase <= PH_WAIT;
            end
          end
          PH_ADDR, PH_WDATA: begin
            if (!busy_i) ack_pend <= 1'b1;
            else         phase    <= PH_WAIT;
          end
          default: ;
        endcase
      end
      if (ack_slot) begin
        ack_pend <= 1'b0;
        unique case (phase)
          PH_CTRL: begin
            phase <= is_read ? PH_RDATA : PH_ADDR;
            if (is_read) ptr <= ptr + AW'(1);
          end
          PH_ADDR: begin
            ptr   <= byte_q;
            phase <= PH_WDATA;
          end
          PH_WDATA: begin
            ptr       <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
            data_seen <= 1'b1;
          end
          PH_RDATA: begin
            if (sda_i) phase <= PH_WAIT;
            else       ptr   <= ptr + AW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  // Registered open-drain enable, updated only while SCL is low.
  always_ff @(posedge clk) begin
    if (rst || start_i || stop_i)
      sda_oe_o <= 1'b0;
    else if (scl_fall_i)
      sda_oe_o <= ack_pend ||
                  (phase == PH_RDATA && bitcnt < DATA_BITS && !tx_msb);
  end

  always_ff @(posedge clk) begin
    if (rst) commit_o <= 1'b0;
    else     commit_o <= commit;
  end

  assert_dev_match_R1: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack_pend) && $past(phase) == PH_CTRL) |->
      $past(rx_byte[DW-1 -: 4]) == DEV_CODE);

  assert_no_ack_busy_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_pend) |-> !$past(busy_i));

  assert_commit_after_stop_R3: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(stop_i));

  assert_page_held_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WDATA && $past(phase) == PH_WDATA) |->
      ptr[AW-1:PW] == $past(ptr[AW-1:PW]));

  assert_released_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT || phase == PH_IDLE) |-> !sda_oe_o);

  assert_oe_low_phase_R10: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_o != $past(sda_oe_o)) |->
      ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));
endmodule

// File: tb/smem_slave_ctrl_tb_top.sv
`timescale 1ns/1ps
module smem_slave_ctrl_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, start_i = 1'b0, stop_i = 1'b0;
  logic scl_rise_i = 1'b0, scl_fall_i = 1'b0, busy_i = 1'b0, sda_m = 1'b1;
  logic sda_oe_o, commit_o, sda_i;
  assign sda_i = sda_m & ~sda_oe_o;

  smem_slave_ctrl dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .scl_rise_i(scl_rise_i), .scl_fall_i(scl_fall_i), .sda_i(sda_i),
    .busy_i(busy_i), .sda_oe_o(sda_oe_o), .commit_o(commit_o)
  );

  typedef struct { string req; logic [15:0] val; } item_t;
  item_t       exp_q[$];
  logic [15:0] got_q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] wbuf [16];

  // Scoreboard monitor: pairs each expected item with the observed one.
  always @(negedge clk) begin
    item_t e;
    logic [15:0] g;
    if (exp_q.size() > 0 && got_q.size() > 0) begin
      e = exp_q.pop_front();
      g = got_q.pop_front();
      checks++;
      if (g !== e.val) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", e.req, g, e.val);
      end
    end
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    item_t it;
    it.req = req; it.val = exp;
    exp_q.push_back(it);
    got_q.push_back(got);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    tick(2);
  endtask

  task automatic do_stop(output bit c);
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
    c = commit_o;
    tick(1);
    sda_m = 1'b1;
  endtask

  task automatic bit_xfer(input bit mb, output bit line, output bit moved);
    bit oe0;
    @(negedge clk) scl_fall_i = 1'b1;
    @(negedge clk) scl_fall_i = 1'b0;
    sda_m = mb;
    oe0 = sda_oe_o;
    tick(2);
    @(negedge clk) begin scl_rise_i = 1'b1; line = sda_i; end
    @(negedge clk) scl_rise_i = 1'b0;
    tick(2);
    moved = (sda_oe_o != oe0);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit l, m, any;
    any = 0;
    for (int i = 7; i >= 0; i--) begin bit_xfer(b[i], l, m); any |= m; end
    bit_xfer(1'b1, l, m); any |= m;
    ack = !l;
    check("R10", {15'd0, any}, 16'd0);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    bit l, m, any;
    any = 0;
    for (int i = 7; i >= 0; i--) begin bit_xfer(1'b1, l, m); d[i] = l; any |= m; end
    bit_xfer(!mack, l, m); any |= m;
    check("R10", {15'd0, any}, 16'd0);
  endtask

  // Write n bytes from wbuf at addr, expecting acks and a commit.
  task automatic write_seq(input logic [7:0] ctrl, input logic [7:0] addr,
                           input int n, input string req);
    bit a, c;
    do_start();
    send_byte(ctrl, a); check("R1", {15'd0, a}, 16'd1);
    send_byte(addr, a); check(req, {15'd0, a}, 16'd1);
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], a); check(req, {15'd0, a}, 16'd1); end
    do_stop(c); check("R3", {15'd0, c}, 16'd1);
    tick(20);
  endtask

  // Random read of n bytes from addr; expected values in wbuf.
  task automatic read_seq(input logic [7:0] addr, input int n, input string req);
    bit a, c;
    logic [7:0] d;
    do_start();
    send_byte(8'hAE, a); check("R1", {15'd0, a}, 16'd1);
    send_byte(addr, a);  check("R6", {15'd0, a}, 16'd1);
    do_start();
    send_byte(8'hA3, a); check("R1", {15'd0, a}, 16'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check(req, {8'd0, d}, {8'd0, wbuf[i]});
    end
    do_stop(c); check("R6", {15'd0, c}, 16'd0);
    tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a, c, l, m, anylow;
    logic [7:0] d;
    tick(4);
    check("R11", {14'd0, sda_oe_o, commit_o}, 16'd0);
    @(negedge clk) rst = 1'b0;
    tick(2);
    check("R11", {14'd0, sda_oe_o, commit_o}, 16'd0);

    // R3 byte write, R6 random read with different don't-care bits, R8 release.
    wbuf[0] = 8'hA5;
    write_seq(8'hA0, 8'h10, 1, "R3");
    wbuf[0] = 8'hA5;
    read_seq(8'h10, 1, "R6");
    do_start();
    send_byte(8'hA1, a); check("R1", {15'd0, a}, 16'd1);
    recv_byte(1'b0, d);
    anylow = 0;
    for (int i = 0; i < 9; i++) begin bit_xfer(1'b1, l, m); if (!l) anylow = 1; end
    check("R8", {15'd0, anylow}, 16'd0);
    do_stop(c);

    // R2 busy withholds all acks, then polling succeeds.
    busy_i = 1'b1;
    do_start();
    send_byte(8'hA0, a); check("R2", {15'd0, a}, 16'd0);
    send_byte(8'h33, a); check("R2", {15'd0, a}, 16'd0);
    do_stop(c); check("R2", {15'd0, c}, 16'd0);
    busy_i = 1'b0;
    do_start();
    send_byte(8'hA0, a); check("R2", {15'd0, a}, 16'd1);
    do_stop(c); check("R2", {15'd0, c}, 16'd0);

    // R1 wrong device code: no ack for anything after it.
    do_start();
    send_byte(8'hB0, a); check("R1", {15'd0, a}, 16'd0);
    send_byte(8'h10, a); check("R1", {15'd0, a}, 16'd0);
    send_byte(8'h00, a); check("R1", {15'd0, a}, 16'd0);
    do_stop(c); check("R1", {15'd0, c}, 16'd0);

    // R5 current-address read after a write.
    wbuf[0] = 8'h22; write_seq(8'hA0, 8'h41, 1, "R3");
    wbuf[0] = 8'h11; write_seq(8'hA4, 8'h40, 1, "R3");
    do_start();
    send_byte(8'hA1, a); check("R5", {15'd0, a}, 16'd1);
    recv_byte(1'b0, d); check("R5", {8'd0, d}, 16'h0022);
    do_stop(c);

    // R4 ten-byte page write from offset 4 of page 0x28.
    for (int i = 0; i < 10; i++) wbuf[i] = 8'h30 + 8'(i);
    write_seq(8'hA0, 8'h2C, 10, "R4");
    do_start();
    send_byte(8'hA1, a);
    recv_byte(1'b0, d); check("R5", {8'd0, d}, 16'h0032);
    do_stop(c);
    wbuf[0] = 8'h34; wbuf[1] = 8'h35; wbuf[2] = 8'h36; wbuf[3] = 8'h37;
    wbuf[4] = 8'h38; wbuf[5] = 8'h39; wbuf[6] = 8'h32; wbuf[7] = 8'h33;
    read_seq(8'h28, 8, "R4");

    // R7 sequential read across 255 -> 0.
    wbuf[0] = 8'h5A; write_seq(8'hA0, 8'hFF, 1, "R3");
    wbuf[0] = 8'hC3; write_seq(8'hA0, 8'h00, 1, "R3");
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    read_seq(8'hFF, 2, "R7");

    // R9 aborts: stop mid-byte, then repeated start after a full data byte.
    wbuf[0] = 8'h77; write_seq(8'hA0, 8'h50, 1, "R3");
    do_start();
    send_byte(8'hA0, a); send_byte(8'h50, a);
    for (int i = 0; i < 4; i++) bit_xfer(1'b1, l, m);
    do_stop(c); check("R9", {15'd0, c}, 16'd0);
    tick(20);
    do_start();
    send_byte(8'hA0, a); send_byte(8'h50, a);
    send_byte(8'h99, a); check("R9", {15'd0, a}, 16'd1);
    do_start();
    do_stop(c); check("R9", {15'd0, c}, 16'd0);
    tick(20);
    do_start();
    send_byte(8'hA0, a); send_byte(8'h50, a);
    for (int i = 0; i < 3; i++) bit_xfer(1'b0, l, m);
    do_start();
    do_stop(c); check("R9", {15'd0, c}, 16'd0);
    tick(20);
    wbuf[0] = 8'h77;
    read_seq(8'h50, 1, "R9");

    tick(5);
    while (exp_q.size() > 0) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule